// File: doc/BRIEF.md
# Qualified Performance Counter Bank

This block holds four independent 48-bit event counters for a processor core. In every cycle the core presents a small per-cycle count for each of eight event sources, the current privilege ring and a one-hot tag for the state of the cache line being touched. Each counter picks one source and increments only when that cycle's activity passes a set of qualifiers. The qualifiers are a threshold compare that can be inverted, detection of rising edges of the qualified condition, filtering on privilege ring, and a mask on cache-line state.

Software programs and reads the counters through a flat register port. A counter that wraps past all ones with its interrupt enable set latches a sticky overflow flag. Any latched flag raises the interrupt request line. Delivering the interrupt and producing the events are left to the surrounding core.

Top module: `pmc_bank`

## Requirements
- R1: The bank has four 48-bit counters. All counters and configuration words are zero after reset. A counter whose enable bit (configuration bit 0) is clear holds its value.
- R2: With a nonzero 3-bit threshold (configuration bits 11:9) and invert clear, the counter adds 1 in each cycle where the selected source's count is at least the threshold.
- R3: With a nonzero threshold and invert (bit 12) set, the counter adds 1 in each cycle where the selected count is below the threshold.
- R4: With threshold 0 and edge mode clear, the counter adds the raw per-cycle count of the selected source, and invert has no effect.
- R5: With edge mode (bit 13) set, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. With threshold 0 the condition is "count nonzero". The stored previous condition is cleared while the counter is disabled.
- R6: Bit 14 enables counting at ring 0 and bit 15 enables counting at rings 1 to 3 (the privilege input is 2 bits). When both bits are clear, all rings count.
- R7: For cache events (event select values 5, 6 and 7), the 5-bit unit mask (bits 21:17) must share a set bit with the one-hot line-state input for the cycle to count. An all-zero mask counts every state. Other events ignore the mask.
- R8: Register address bit 2 set selects a configuration word and clear selects a counter; address bits 1:0 give the counter index. Reads are combinational. A configuration read returns the 22 written bits, with the overflow flag in bit 22.
- R9: A counter write takes effect at the next clock edge and overrides any increment in that cycle.
- R10: When an increment carries a counter from all ones through zero, the counter wraps. If its interrupt enable (bit 16) is set, its overflow flag is set and stays set. Writing 1 to bit 22 of the configuration word clears the flag. The interrupt output is high while any flag is set.
- R11: An event select value of 8 or above selects no source, and the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cnt_i | input | 24 | Eight 3-bit per-cycle event counts; source k occupies bits 3k+2:3k |
| priv_i | input | 2 | Current privilege ring |
| line_state_i | input | 5 | One-hot cache-line state tag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 48 | Register write data |
| reg_rdata_o | output | 48 | Register read data |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- a counter write wins over a same-cycle increment;
- a disabled counter holds its value;
- with a threshold set, a counter advances by at most one per cycle;
- in edge mode, a counter does not advance while the previous condition is still true;
- the stored edge bit is cleared while a counter is disabled;
- an overflow flag only rises when the interrupt enable was set.

Only the directed scenarios show the values that result. These include the threshold and inverted sums, the number of rising edges counted, privilege and unit-mask filtering, the counts left after a wrap, and clearing the flag by writing 1 to it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CFG_W   = 22;
  localparam int OVF_BIT = 22;

  // configuration word, MSB first
  typedef struct packed {
    logic [4:0] umask;
    logic       int_en;
    logic       usr_en;
    logic       os_en;
    logic       edg;
    logic       inv;
    logic [2:0] thr;
    logic [7:0] sel;
    logic       en;
  } pmc_cfg_t;

  // threshold compare; threshold 0 means "any activity"
  function automatic logic thresh_pass(input logic [7:0] cnt, input logic [2:0] thr,
                                       input logic inv);
    logic [7:0] t;
    t = {5'd0, thr};
    if (thr == 3'd0) return (cnt != 8'd0);
    return inv ? (cnt < t) : (cnt >= t);
  endfunction

  function automatic logic priv_ok(input logic [1:0] ring, input logic os_en,
                                   input logic usr_en);
    logic both;
    both = !os_en && !usr_en;
    return (ring == 2'd0) ? (os_en || both) : (usr_en || both);
  endfunction

  function automatic logic mask_ok(input logic [4:0] umask, input logic [4:0] state,
                                   input logic is_cache);
    return !is_cache || (umask == 5'd0) || ((umask & state) != 5'd0);
  endfunction

endpackage

// File: rtl/pmc_qualifier.sv
module pmc_qualifier
  import pmc_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int EVT_W        = 3,
  parameter int CACHE_SEL_LO = 5,
  parameter int CACHE_SEL_HI = 7
) (
  input  pmc_cfg_t                   cfg_i,
  input  logic [NUM_SRC*EVT_W-1:0]   evt_cnt_i,
  input  logic [1:0]                 priv_i,
  input  logic [4:0]                 line_state_i,
  output logic                       cond_o,
  output logic [EVT_W-1:0]           level_inc_o
);

  logic [EVT_W-1:0] raw_cnt;
  logic             is_cache;
  logic             allow;

  always_comb begin
    raw_cnt = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cfg_i.sel == 8'(s)) raw_cnt = evt_cnt_i[s*EVT_W +: EVT_W];
    end
  end

  assign is_cache = (cfg_i.sel >= 8'(CACHE_SEL_LO)) && (cfg_i.sel <= 8'(CACHE_SEL_HI));
  assign allow    = cfg_i.en && priv_ok(priv_i, cfg_i.os_en, cfg_i.usr_en)
                    && mask_ok(cfg_i.umask, line_state_i, is_cache);
  assign cond_o   = allow && thresh_pass(8'(raw_cnt), cfg_i.thr, cfg_i.inv);

  always_comb begin
    if (!allow)                level_inc_o = '0;
    else if (cfg_i.thr == 3'd0) level_inc_o = raw_cnt;
    else                       level_inc_o = EVT_W'(cond_o);
  end

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic             cnt_we_i,
  input  logic             cond_i,
  input  logic [EVT_W-1:0] level_inc_i,
  output pmc_cfg_t         cfg_o,
  output logic [CTR_W-1:0] cnt_o,
  output logic             ovf_o
);

  pmc_cfg_t         cfg_q;
  logic [CTR_W-1:0] cnt_q;
  logic             ovf_q;
  logic             prev_q;
  logic [EVT_W-1:0] inc;
  logic [CTR_W:0]   sum;
  logic             wrap_evt;
  logic             ovf_clr;

  always_comb begin
    if (!cfg_q.en)     inc = '0;
    else if (cfg_q.edg) inc = EVT_W'(cond_i && !prev_q);
    else               inc = level_inc_i;
  end

  assign sum      = {1'b0, cnt_q} + (CTR_W+1)'(inc);
  assign wrap_evt = sum[CTR_W] && cfg_q.int_en && !cnt_we_i;
  assign ovf_clr  = cfg_we_i && wdata_i[OVF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= pmc_cfg_t'(wdata_i[CFG_W-1:0]);
      cnt_q  <= cnt_we_i ? wdata_i : sum[CTR_W-1:0];
      prev_q <= cfg_q.en ? cond_i : 1'b0;
      if (wrap_evt)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> cnt_q == $past(wdata_i)); // R9
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.en && !cnt_we_i) |=> $stable(cnt_q)); // R1
  AST_THR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.thr != 3'd0 && !cnt_we_i) |=> ((cnt_q - $past(cnt_q)) <= CTR_W'(1))); // R2
  AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.edg && prev_q && !cnt_we_i) |=> $stable(cnt_q)); // R5
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |=> !prev_q); // R5
  AST_OVF_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(cfg_q.int_en)); // R10

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int NUM_SRC = 8,
  parameter int EVT_W   = 3,
  localparam int IDX_W  = $clog2(NUM_CTR),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC*EVT_W-1:0] evt_cnt_i,
  input  logic [1:0]               priv_i,
  input  logic [4:0]               line_state_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [CTR_W-1:0]         reg_wdata_i,
  output logic [CTR_W-1:0]         reg_rdata_o,
  output logic                     irq_o
);

  pmc_cfg_t         cfg   [NUM_CTR];
  logic [CTR_W-1:0] cnt   [NUM_CTR];
  logic [NUM_CTR-1:0] ovf;
  logic [IDX_W-1:0] idx;
  logic             is_cfg;

  assign idx    = reg_addr_i[IDX_W-1:0];
  assign is_cfg = reg_addr_i[IDX_W];

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    logic             cond;
    logic [EVT_W-1:0] level_inc;
    logic             sel_me;

    assign sel_me = reg_we_i && (idx == IDX_W'(c));

    pmc_qualifier #(.NUM_SRC(NUM_SRC), .EVT_W(EVT_W)) u_qual (
      .cfg_i        (cfg[c]),
      .evt_cnt_i    (evt_cnt_i),
      .priv_i       (priv_i),
      .line_state_i (line_state_i),
      .cond_o       (cond),
      .level_inc_o  (level_inc)
    );

    pmc_counter #(.CTR_W(CTR_W), .EVT_W(EVT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (sel_me && is_cfg),
      .wdata_i     (reg_wdata_i),
      .cnt_we_i    (sel_me && !is_cfg),
      .cond_i      (cond),
      .level_inc_i (level_inc),
      .cfg_o       (cfg[c]),
      .cnt_o       (cnt[c]),
      .ovf_o       (ovf[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CTR; c++) begin
      if (idx == IDX_W'(c))
        reg_rdata_o = is_cfg ? CTR_W'({ovf[c], cfg[c]}) : cnt[c];
    end
  end

  assign irq_o = |ovf;

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == '0) |-> !irq_o); // R10

endmodule

// File: tb/test_pmc_bank.sv
`timescale 1ns/1ps
module test_pmc_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt_cnt_i = '0;
  logic [1:0]  priv_i = '0;
  logic [4:0]  line_state_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [47:0] reg_wdata_i = '0;
  logic [47:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmc_bank i_pmc_bank (.*);

  function automatic logic [47:0] mk_cfg(input bit en, input int sel, input int thr,
      input bit inv, input bit edg, input bit os, input bit usr, input bit ie,
      input logic [4:0] um);
    logic [47:0] w;
    w = '0;
    w[0] = en; w[8:1] = 8'(sel); w[11:9] = 3'(thr); w[12] = inv; w[13] = edg;
    w[14] = os; w[15] = usr; w[16] = ie; w[21:17] = um;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int addr, input logic [47:0] d);
    reg_we_i = 1'b1; reg_addr_i = 3'(addr); reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [47:0] d);
    reg_addr_i = 3'(addr); #1; d = reg_rdata_o;
  endtask

  task automatic expect_ctr(input int c, input logic [47:0] exp, input string tag);
    logic [47:0] v;
    rd(c, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic set_src(input int s, input int v);
    evt_cnt_i[s*3 +: 3] = 3'(v);
  endtask

  task automatic clear_all();
    for (int c = 0; c < 4; c++) wr(4 + c, 48'd0);
    for (int c = 0; c < 4; c++) wr(c, 48'd0);
  endtask

  task automatic t_reset();
    logic [47:0] v;
    for (int c = 0; c < 4; c++) begin
      rd(c, v);     check(v == 0, "R1 counter reset", v, 0);
      rd(4 + c, v); check(v == 0, "R8 config reset", v, 0);
    end
    check(irq_o == 0, "R10 irq reset", 48'(irq_o), 0);
  endtask

  task automatic t_threshold();
    int seq[5] = '{5, 3, 4, 7, 0};
    logic [47:0] v;
    clear_all();
    wr(4, mk_cfg(1, 2, 0, 0, 0, 0, 0, 0, 0));
    wr(5, mk_cfg(1, 2, 0, 1, 0, 0, 0, 0, 0));
    wr(6, mk_cfg(1, 2, 4, 0, 0, 0, 0, 0, 0));
    wr(7, mk_cfg(1, 2, 4, 1, 0, 0, 0, 0, 0));
    rd(7, v);
    check(v == mk_cfg(1, 2, 4, 1, 0, 0, 0, 0, 0), "R8 config readback", v,
          mk_cfg(1, 2, 4, 1, 0, 0, 0, 0, 0));
    set_src(1, 7); set_src(3, 6);
    foreach (seq[i]) begin set_src(2, seq[i]); tick(); end
    evt_cnt_i = '0;
    expect_ctr(0, 19, "R4 raw sum");
    expect_ctr(1, 19, "R4 invert ignored at threshold 0");
    expect_ctr(2, 3,  "R2 threshold >= 4");
    expect_ctr(3, 2,  "R3 inverted threshold < 4");
  endtask

  task automatic t_edge();
    int seq[7] = '{2, 3, 0, 1, 1, 0, 4};
    clear_all();
    wr(4, mk_cfg(1, 1, 0, 0, 1, 0, 0, 0, 0));
    foreach (seq[i]) begin set_src(1, seq[i]); tick(); end
    set_src(1, 0); tick();
    expect_ctr(0, 3, "R5 rising edges");
    wr(0, 0);
    set_src(1, 2); tick(); tick(); tick();
    expect_ctr(0, 1, "R5 held condition counts once");
    wr(4, mk_cfg(0, 1, 0, 0, 1, 0, 0, 0, 0));
    tick(); tick();
    expect_ctr(0, 1, "R1 disabled counter holds");
    wr(4, mk_cfg(1, 1, 0, 0, 1, 0, 0, 0, 0));
    tick();
    expect_ctr(0, 2, "R5 edge state cleared while disabled");
    set_src(1, 0);
  endtask

  task automatic t_priv();
    clear_all();
    wr(4, mk_cfg(1, 0, 0, 0, 0, 1, 0, 0, 0));
    wr(5, mk_cfg(1, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(6, mk_cfg(1, 0, 0, 0, 0, 1, 1, 0, 0));
    wr(7, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0));
    set_src(0, 2);
    priv_i = 2'd0; tick();
    priv_i = 2'd3; tick();
    priv_i = 2'd1; tick();
    set_src(0, 0); priv_i = 2'd0;
    expect_ctr(0, 2, "R6 ring 0 only");
    expect_ctr(1, 4, "R6 rings 1-3 only");
    expect_ctr(2, 6, "R6 both enabled");
    expect_ctr(3, 6, "R6 neither means both");
  endtask

  task automatic t_mask();
    clear_all();
    wr(4, mk_cfg(1, 5, 0, 0, 0, 0, 0, 0, 5'b00100));
    wr(5, mk_cfg(1, 5, 0, 0, 0, 0, 0, 0, 5'b00000));
    wr(6, mk_cfg(1, 4, 0, 0, 0, 0, 0, 0, 5'b00001));
    wr(7, mk_cfg(1, 9, 0, 0, 0, 0, 0, 0, 5'b00000));
    set_src(5, 3); set_src(4, 3); set_src(0, 7); set_src(1, 7);
    line_state_i = 5'b00100; tick();
    line_state_i = 5'b00010; tick();
    evt_cnt_i = '0; line_state_i = '0;
    expect_ctr(0, 3, "R7 mask selects state");
    expect_ctr(1, 6, "R7 empty mask counts all");
    expect_ctr(2, 6, "R7 mask ignored for non-cache event");
    expect_ctr(3, 0, "R11 out-of-range select");
  endtask

  task automatic t_write_prio();
    clear_all();
    wr(4, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0));
    set_src(0, 7);
    wr(0, 100);
    expect_ctr(0, 100, "R9 write overrides increment");
    tick();
    set_src(0, 0);
    expect_ctr(0, 107, "R9 counting resumes");
  endtask

  task automatic t_overflow();
    logic [47:0] v;
    clear_all();
    wr(4, mk_cfg(1, 0, 0, 0, 0, 0, 0, 1, 0));
    wr(5, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(0, 48'hFFFF_FFFF_FFFE);
    wr(1, 48'hFFFF_FFFF_FFFE);
    set_src(0, 3); tick(); set_src(0, 0);
    expect_ctr(0, 1, "R10 wrap value");
    expect_ctr(1, 1, "R10 wrap value without int enable");
    rd(4, v); check(v[22] == 1, "R10 flag set", 48'(v[22]), 1);
    rd(5, v); check(v[22] == 0, "R10 no flag without int enable", 48'(v[22]), 0);
    check(irq_o == 1, "R10 irq raised", 48'(irq_o), 1);
    tick();
    check(irq_o == 1, "R10 flag sticky", 48'(irq_o), 1);
    wr(4, mk_cfg(1, 0, 0, 0, 0, 0, 0, 1, 0) | (48'd1 << 22));
    rd(4, v); check(v[22] == 0, "R10 write-1 clears flag", 48'(v[22]), 0);
    check(irq_o == 0, "R10 irq cleared", 48'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_threshold();
    t_edge();
    t_priv();
    t_mask();
    t_write_prio();
    t_overflow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule